// File: doc/BRIEF.md
# Issue Queue with Tag Wakeup and Age-Ordered Select

This block holds renamed operations until their source operands are available, then sends them to a fixed set of functional-unit ports. Each slot keeps an opcode, the destination tag, and for each of two sources either a ready bit or the tag of the producing operation. Result tags broadcast on one or more result buses are compared against every waiting source tag. A source that matches is marked ready.

Each cycle, the select stage ranks the eligible slots by age. An eligible slot is one that is valid with both sources ready. The oldest eligible slot goes to port 0, the next oldest to port 1, and so on up to the issue width. A slot is freed in the cycle it issues. Dispatch is refused while every slot is occupied. A flush empties the queue in one cycle. Operand values, execution and bypass data paths belong to neighbouring blocks.

Top module: `issue_queue`

## Requirements
- R1: After reset, no issue port is valid and `disp_ready_o` is 1.
- R2: An operation dispatched with both sources ready appears on port 0 in the cycle after it is accepted, carrying its opcode and destination tag.
- R3: A source dispatched as not ready blocks issue until a valid broadcast carries its tag on any bus. The operation then issues in the cycle after that broadcast.
- R4: A broadcast whose valid bit is low, or whose tag differs from the waiting tag, leaves the operation waiting.
- R5: A broadcast in the same cycle as the dispatch that needs it still wakes the dispatched source.
- R6: When more operations are eligible than there are ports, port p carries the (p+1)-th oldest eligible operation, where age is dispatch order. Ports fill from port 0 upward, and the remaining operations issue in later cycles, still oldest first.
- R7: An issued operation is removed at the end of its issue cycle and never issues again. No operation appears on two ports in one cycle.
- R8: While all slots are valid, `disp_ready_o` is 0 and a dispatch attempt is dropped.
- R9: A flush clears every slot in one cycle. A dispatch offered during the flush is dropped, and no port is valid while the flush is asserted.
- R10: An operation with only one of its two sources ready does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all queued operations |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | A free slot exists |
| disp_op_i | input | OP_W | Opcode of dispatched operation |
| disp_dst_i | input | TAG_W | Destination tag |
| disp_src_tag_i | input | 2*TAG_W | Source tags, source 0 in the low bits |
| disp_src_rdy_i | input | 2 | Source ready bits, bit 0 for source 0 |
| bc_valid_i | input | NUM_BCAST | Result bus valid bits |
| bc_tag_i | input | NUM_BCAST*TAG_W | Result bus tags, bus 0 in the low bits |
| iss_valid_o | output | ISSUE_W | Per-port issue valid |
| iss_op_o | output | ISSUE_W*OP_W | Per-port opcode, port 0 in the low bits |
| iss_dst_o | output | ISSUE_W*TAG_W | Per-port destination tag, port 0 in the low bits |

## Verification
Every result appears one clock edge after its cause:
- A ready dispatch shows on a port just after the edge that accepts it.
- A broadcast makes its consumer issue just after the following edge.
- An issued slot is gone after the edge that ends its issue cycle.
- A flush leaves the queue empty after one edge.

The bench applies each stimulus just after an edge and lets exactly one edge pass. It then returns all inputs to idle and samples the ports a nanosecond later. Each check therefore sees the state produced by that one edge. A sweep covers every tag value, each source slot and each bus, and expected port contents follow arithmetically from dispatch order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int unsigned TAG_W     = 6,
  parameter int unsigned NUM_BCAST = 2
) (
  input  logic [TAG_W-1:0]           tag_i,
  input  logic [NUM_BCAST-1:0]       bc_valid_i,
  input  logic [NUM_BCAST*TAG_W-1:0] bc_tag_i,
  output logic                       hit_o
);
  logic [NUM_BCAST-1:0] bus_hit;

  for (genvar b = 0; b < NUM_BCAST; b++) begin : g_bus
    assign bus_hit[b] = bc_valid_i[b] && (bc_tag_i[b*TAG_W +: TAG_W] == tag_i);
  end

  assign hit_o = |bus_hit;
endmodule

// File: rtl/iq_age_matrix.sv
// older_o[i][j] = 1 when slot i was written before slot j
module iq_age_matrix #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DEPTH-1:0]            alloc_i,
  output logic [DEPTH-1:0][DEPTH-1:0] older_o
);
  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (alloc_i[i])      older_q[i][j] <= 1'b0;
          else if (alloc_i[j]) older_q[i][j] <= (i != j);
        end
      end
    end
  end

  assign older_o = older_q;
endmodule

// File: rtl/iq_select.sv
// Rank each requester by the number of older requesters; rank p goes to port p.
module iq_select #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ISSUE_W = 6
) (
  input  logic [DEPTH-1:0]              req_i,
  input  logic [DEPTH-1:0][DEPTH-1:0]   older_i,
  output logic [ISSUE_W-1:0][DEPTH-1:0] grant_o
);
  localparam int unsigned RANK_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][RANK_W-1:0] rank;

  for (genvar e = 0; e < DEPTH; e++) begin : g_rank
    logic [DEPTH-1:0] older_col;
    always_comb begin
      for (int j = 0; j < DEPTH; j++) older_col[j] = older_i[j][e] & req_i[j];
      rank[e] = RANK_W'($countones(older_col));
    end
    for (genvar p = 0; p < ISSUE_W; p++) begin : g_port
      assign grant_o[p][e] = req_i[e] && (rank[e] == RANK_W'(p));
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned ISSUE_W   = 6,
  parameter int unsigned NUM_BCAST = 2,
  parameter int unsigned TAG_W     = 6,
  parameter int unsigned OP_W      = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         disp_valid_i,
  output logic                         disp_ready_o,
  input  logic [OP_W-1:0]              disp_op_i,
  input  logic [TAG_W-1:0]             disp_dst_i,
  input  logic [NUM_SRC*TAG_W-1:0]     disp_src_tag_i,
  input  logic [NUM_SRC-1:0]           disp_src_rdy_i,
  input  logic [NUM_BCAST-1:0]         bc_valid_i,
  input  logic [NUM_BCAST*TAG_W-1:0]   bc_tag_i,
  output logic [ISSUE_W-1:0]           iss_valid_o,
  output logic [ISSUE_W*OP_W-1:0]      iss_op_o,
  output logic [ISSUE_W*TAG_W-1:0]     iss_dst_o
);
  typedef struct packed {
    logic [OP_W-1:0]                 op;
    logic [TAG_W-1:0]                dst;
    logic [NUM_SRC-1:0][TAG_W-1:0]   tag;
    logic [NUM_SRC-1:0]              rdy;
  } entry_t;

  logic [DEPTH-1:0]                valid_q;
  entry_t                          ent_q [DEPTH];
  logic [DEPTH-1:0][NUM_SRC-1:0]   wake_hit;
  logic [NUM_SRC-1:0]              disp_hit;
  logic [DEPTH-1:0]                alloc_oh;
  logic [DEPTH-1:0]                alloc_we;
  logic                            disp_fire;
  logic [DEPTH-1:0]                eligible;
  logic [DEPTH-1:0]                req;
  logic [DEPTH-1:0][DEPTH-1:0]     older;
  logic [ISSUE_W-1:0][DEPTH-1:0]   grant;
  logic [DEPTH-1:0]                grant_any;
  entry_t                          new_ent;

  // wakeup compare: every slot, every source, every bus
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      iq_tag_match #(.TAG_W(TAG_W), .NUM_BCAST(NUM_BCAST)) u_wake (
        .tag_i      (ent_q[e].tag[s]),
        .bc_valid_i (bc_valid_i),
        .bc_tag_i   (bc_tag_i),
        .hit_o      (wake_hit[e][s])
      );
    end
    assign eligible[e] = valid_q[e] && (&ent_q[e].rdy);
  end

  // same-cycle broadcast seen by the operation being written
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_disp_src
    iq_tag_match #(.TAG_W(TAG_W), .NUM_BCAST(NUM_BCAST)) u_disp (
      .tag_i      (disp_src_tag_i[s*TAG_W +: TAG_W]),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .hit_o      (disp_hit[s])
    );
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_q[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign disp_ready_o = |(~valid_q);
  assign disp_fire    = disp_valid_i && disp_ready_o && !flush_i;
  assign alloc_we     = alloc_oh & {DEPTH{disp_fire}};
  assign req          = eligible & {DEPTH{!flush_i}};

  always_comb begin
    new_ent.op  = disp_op_i;
    new_ent.dst = disp_dst_i;
    new_ent.tag = disp_src_tag_i;
    new_ent.rdy = disp_src_rdy_i | disp_hit;
  end

  iq_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_we),
    .older_o (older)
  );

  iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_sel (
    .req_i   (req),
    .older_i (older),
    .grant_o (grant)
  );

  always_comb begin
    grant_any = '0;
    for (int p = 0; p < ISSUE_W; p++) grant_any |= grant[p];
  end

  for (genvar p = 0; p < ISSUE_W; p++) begin : g_port
    logic [OP_W-1:0]  op_mux;
    logic [TAG_W-1:0] dst_mux;
    always_comb begin
      op_mux  = '0;
      dst_mux = '0;
      for (int e = 0; e < DEPTH; e++) begin
        if (grant[p][e]) begin
          op_mux  |= ent_q[e].op;
          dst_mux |= ent_q[e].dst;
        end
      end
    end
    assign iss_valid_o[p]                 = |grant[p];
    assign iss_op_o[p*OP_W +: OP_W]       = op_mux;
    assign iss_dst_o[p*TAG_W +: TAG_W]    = dst_mux;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else              valid_q <= (valid_q & ~grant_any) | alloc_we;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) ent_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_we[e])     ent_q[e] <= new_ent;
        else if (valid_q[e]) ent_q[e].rdy <= ent_q[e].rdy | wake_hit[e];
      end
    end
  end
endmodule

// File: rtl/iq_chk.sv
module iq_chk #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ISSUE_W = 6
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              flush_i,
  input logic                              disp_ready_i,
  input logic [DEPTH-1:0]                  valid_i,
  input logic [DEPTH-1:0]                  elig_i,
  input logic [ISSUE_W-1:0][DEPTH-1:0]     grant_i,
  input logic [ISSUE_W-1:0]                iss_valid_i
);
  logic [DEPTH-1:0] g_union;
  int               g_total;

  always_comb begin
    g_union = '0;
    g_total = 0;
    for (int p = 0; p < ISSUE_W; p++) begin
      g_union |= grant_i[p];
      g_total += $countones(grant_i[p]);
    end
  end

  // R7
  no_dup_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_total == $countones(g_union));

  // R7
  freed_after_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|g_union) |=> ((valid_i & $past(g_union)) == '0));

  // R10
  ready_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_union & ~elig_i) == '0);

  // R8
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_i) |-> !disp_ready_i);

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_i == '0));

  // R9
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (iss_valid_i == '0));

  // R6
  full_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && ($countones(elig_i) >= ISSUE_W)) |-> (&iss_valid_i));

  for (genvar p = 1; p < ISSUE_W; p++) begin : g_contig
    // R6
    port_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_i[p] |-> iss_valid_i[p-1]);
  end
endmodule

bind issue_queue iq_chk #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_iq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .disp_ready_i (disp_ready_o),
  .valid_i      (valid_q),
  .elig_i       (eligible),
  .grant_i      (grant),
  .iss_valid_i  (iss_valid_o)
);

// File: tb/issue_queue_bench.sv
`timescale 1ns/1ps
module issue_queue_bench;
  localparam int DEPTH = 8;
  localparam int ISSUE_W = 3;
  localparam int NUM_BCAST = 2;
  localparam int TAG_W = 4;
  localparam int OP_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i;
  logic disp_valid_i;
  logic disp_ready_o;
  logic [OP_W-1:0] disp_op_i;
  logic [TAG_W-1:0] disp_dst_i;
  logic [2*TAG_W-1:0] disp_src_tag_i;
  logic [1:0] disp_src_rdy_i;
  logic [NUM_BCAST-1:0] bc_valid_i;
  logic [NUM_BCAST*TAG_W-1:0] bc_tag_i;
  logic [ISSUE_W-1:0] iss_valid_o;
  logic [ISSUE_W*OP_W-1:0] iss_op_o;
  logic [ISSUE_W*TAG_W-1:0] iss_dst_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  issue_queue #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .NUM_BCAST(NUM_BCAST),
                .TAG_W(TAG_W), .OP_W(OP_W)) u_issue_queue (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .disp_valid_i(disp_valid_i), .disp_ready_o(disp_ready_o),
    .disp_op_i(disp_op_i), .disp_dst_i(disp_dst_i),
    .disp_src_tag_i(disp_src_tag_i), .disp_src_rdy_i(disp_src_rdy_i),
    .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i),
    .iss_valid_o(iss_valid_o), .iss_op_o(iss_op_o), .iss_dst_o(iss_dst_o)
  );

  task automatic idle();
    flush_i = 1'b0; disp_valid_i = 1'b0; disp_op_i = '0; disp_dst_i = '0;
    disp_src_tag_i = '0; disp_src_rdy_i = '0; bc_valid_i = '0; bc_tag_i = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle(); #1;
  endtask

  task automatic disp(input int op, input int dst, input int t0, input int r0,
                      input int t1, input int r1);
    disp_valid_i = 1'b1;
    disp_op_i = OP_W'(op);
    disp_dst_i = TAG_W'(dst);
    disp_src_tag_i = {TAG_W'(t1), TAG_W'(t0)};
    disp_src_rdy_i = {r1[0], r0[0]};
  endtask

  task automatic bc(input int b, input int tag, input bit v);
    bc_valid_i[b] = v;
    bc_tag_i[b*TAG_W +: TAG_W] = TAG_W'(tag);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic exp_port(input int p, input int op, input string req);
    chk(iss_valid_o[p] === 1'b1, req, int'(iss_valid_o[p]), 1);
    chk(int'(iss_op_o[p*OP_W +: OP_W]) == op, req, int'(iss_op_o[p*OP_W +: OP_W]), op);
  endtask

  task automatic exp_none_from(input int first, input string req);
    for (int p = first; p < ISSUE_W; p++)
      chk(iss_valid_o[p] === 1'b0, req, int'(iss_valid_o[p]), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1; #1;
    // R1
    exp_none_from(0, "R1");
    chk(disp_ready_o === 1'b1, "R1", int'(disp_ready_o), 1);

    // R2 ready at dispatch
    disp(5, 9, 0, 1, 0, 1); tick();
    exp_port(0, 5, "R2");
    chk(int'(iss_dst_o[0 +: TAG_W]) == 9, "R2", int'(iss_dst_o[0 +: TAG_W]), 9);
    exp_none_from(1, "R2");
    tick();
    exp_none_from(0, "R7");

    // R3 / R4 sweep over tag, source slot and bus
    for (int t = 0; t < 16; t++) begin
      for (int s = 0; s < 2; s++) begin
        for (int b = 0; b < 2; b++) begin
          int op;
          op = t * 4 + s * 2 + b;
          if (s == 0) disp(op, t, t, 0, 0, 1);
          else        disp(op, t, 0, 1, t, 0);
          tick();
          exp_none_from(0, "R3");
          bc(b, t ^ 1, 1'b1);
          bc(1 - b, t, 1'b0);
          tick();
          exp_none_from(0, "R4");
          bc(b, t, 1'b1);
          tick();
          exp_port(0, op, "R3");
          tick();
          exp_none_from(0, "R7");
        end
      end
    end

    // R10 both sources required
    disp(40, 1, 3, 0, 4, 0); tick();
    bc(0, 3, 1'b1); tick();
    exp_none_from(0, "R10");
    bc(1, 4, 1'b1); tick();
    exp_port(0, 40, "R10");
    tick();

    // R5 broadcast in dispatch cycle
    disp(41, 2, 0, 1, 9, 0); bc(0, 9, 1'b1); tick();
    exp_port(0, 41, "R5");
    tick();
    exp_none_from(0, "R7");

    // R8 / R6 fill and age order
    for (int i = 0; i < DEPTH; i++) begin
      disp(i, i, (i < 3) ? 2 : 7, 0, 0, 1); tick();
    end
    chk(disp_ready_o === 1'b0, "R8", int'(disp_ready_o), 0);
    disp(50, 0, 0, 1, 0, 1); tick();
    exp_none_from(0, "R8");
    chk(disp_ready_o === 1'b0, "R8", int'(disp_ready_o), 0);
    bc(1, 2, 1'b1); tick();
    for (int p = 0; p < ISSUE_W; p++) exp_port(p, p, "R6");
    tick();
    chk(disp_ready_o === 1'b1, "R7", int'(disp_ready_o), 1);
    for (int i = 8; i < 11; i++) begin
      disp(i, i, 7, 0, 0, 1); tick();
    end
    chk(disp_ready_o === 1'b0, "R8", int'(disp_ready_o), 0);
    bc(0, 7, 1'b1); tick();
    for (int p = 0; p < ISSUE_W; p++) exp_port(p, 3 + p, "R6");
    tick();
    for (int p = 0; p < ISSUE_W; p++) exp_port(p, 6 + p, "R6");
    tick();
    exp_port(0, 9, "R6");
    exp_port(1, 10, "R6");
    exp_none_from(2, "R6");
    tick();
    exp_none_from(0, "R7");
    chk(disp_ready_o === 1'b1, "R8", int'(disp_ready_o), 1);

    // R9 flush
    for (int i = 0; i < 3; i++) begin
      disp(20 + i, 0, 12, 0, 0, 1); tick();
    end
    flush_i = 1'b1;
    disp(60, 0, 0, 1, 0, 1);
    tick();
    exp_none_from(0, "R9");
    bc(0, 12, 1'b1); tick();
    exp_none_from(0, "R9");
    for (int i = 0; i < DEPTH; i++) begin
      disp(30 + i, 0, 5, 0, 0, 1); tick();
    end
    chk(disp_ready_o === 1'b0, "R9", int'(disp_ready_o), 0);
    flush_i = 1'b1; tick();
    chk(disp_ready_o === 1'b1, "R9", int'(disp_ready_o), 1);

    summary();
    $finish;
  end
endmodule